// File: doc/BRIEF.md
# Address-Range Cache Line Scrubber

This block keeps the tag state of a set-associative data cache. It removes only the lines whose addresses fall inside a memory range that a storage DMA engine has just overwritten. When a transfer from storage has landed in memory, the IO side sends a base address and a page count. The scrubber then walks the tag array one set per cycle and compares every way of that set against the range bounds in parallel. A clean match is marked invalid at once and causes no memory traffic. A dirty match is first offered on a writeback port. It is marked invalid only after that port accepts the line, so written data is never lost.

Normal cache lookups and fills share the tag array with the walk and take priority over it. If a lookup or fill touches the set the walk is visiting, the walk waits for that cycle. A single-cycle done pulse marks the end of each request. After a scrub, any access to a removed address misses, and the freed way is the first choice for the next fill in its set.

Top module: `range_scrubber`

## Requirements
- R1: After reset, reqReady is high, donePulse and wbValid are low, and every lookup misses.
- R2: A request covers the half-open byte range [P, P + reqPages × 4096), where P is the start of the 4 KB page that contains reqBase. When the request completes, every line whose line address lies inside that range is invalid. Every other line keeps its valid and dirty state.
- R3: A clean line inside the range is invalidated without appearing on the writeback port.
- R4: A dirty line inside the range is offered on wbValid/wbAddr with its line-aligned address. It stays valid until a cycle in which wbValid and wbReady are both high, and each such line is written back exactly once.
- R5: After a scrub, a lookup of a removed address misses, and lkVictim for that set names the lowest-numbered invalid way.
- R6: reqReady is low while a walk is in progress. Suppose a request with a nonzero page count is accepted at clock edge k, and the walk meets no conflicting access and no dirty match. Then donePulse is high for exactly the cycle after edge k + SETS (SETS = 16 by default).
- R7: If lkValid or fillValid addresses the set being walked, the walk does not advance in that cycle, wbValid is low, and the lookup sees the unchanged tag state. Each such cycle delays donePulse by one cycle.
- R8: A request with reqPages = 0 raises donePulse in the cycle after it is accepted. It changes no line and offers no writeback.
- R9: The low 12 bits of reqBase do not affect which lines are removed.
- R10: A fill installs its line, with the dirty flag taken from fillDirty, into the lowest-numbered invalid way of its set. If the set has no invalid way, the fill uses a per-set rotating way. A lookup with lkWrite set that hits marks the line dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Scrub request valid |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqBase | input | 64 | Byte address inside the first page of the range |
| reqPages | input | 16 | Number of 4 KB pages in the range |
| donePulse | output | 1 | One-cycle pulse when a request has completed |
| lkValid | input | 1 | Cache lookup valid |
| lkAddr | input | 64 | Lookup byte address; also selects the set for lkVictim |
| lkWrite | input | 1 | Lookup is a store; a hit marks the line dirty |
| lkHit | output | 1 | Lookup address is present and valid |
| lkWay | output | 2 | Way that hit |
| lkVictim | output | 2 | Way the next fill to lkAddr's set would use |
| fillValid | input | 1 | Install a line |
| fillAddr | input | 64 | Byte address of the line to install |
| fillDirty | input | 1 | Dirty flag of the installed line |
| wbValid | output | 1 | Dirty line offered for writeback |
| wbAddr | output | 64 | Line address of the offered line |
| wbReady | input | 1 | Writeback port accepts the offered line |

## Verification
The hardest state to reach from the ports is a dirty in-range line that is waiting on the writeback port while a normal lookup arrives for the same set. The bench sets this up by filling sets so that dirty lines sit inside each scrub range. On the first writeback offer of each request it holds wbReady low and issues a lookup to the offered address in the same cycle. It then expects a hit and a withdrawn offer. The bench sweeps aligned, unaligned, zero-length, full-span and empty ranges, refilling the freed ways between requests. It also measures walk latency with and without a conflicting lookup.

// File: rtl/scrub_pkg.sv
`timescale 1ns/1ps
package scrub_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walkState_t;

  // strobes from the walk controller into the datapath
  typedef struct packed {
    logic loadRange;  // capture bounds of a newly accepted request
    logic scrubEn;    // walk owns the current set this cycle
    logic wbOffer;    // present the selected dirty match on the writeback port
  } scrubStrobe_t;

endpackage

// File: rtl/scrub_ctrl.sv
`timescale 1ns/1ps
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int SET_BITS = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [CNT_W-1:0]    reqPages,
  input  logic                conflict,
  input  logic                anyDirty,
  input  logic                oneDirty,
  input  logic                wbReady,
  output logic                reqReady,
  output logic                donePulse,
  output scrubStrobe_t        strobe,
  output logic [SET_BITS-1:0] walkSet
);

  walkState_t          state;
  logic [SET_BITS-1:0] setIdx;
  logic                doneQ;
  logic                active;
  logic                advance;
  logic                lastSet;

  assign walkSet   = setIdx;
  assign donePulse = doneQ;
  assign lastSet   = (setIdx == {SET_BITS{1'b1}});

  always_comb begin
    reqReady         = (state == ST_IDLE);
    active           = (state == ST_WALK) && !conflict;
    strobe.loadRange = reqReady && reqValid;
    strobe.scrubEn   = active;
    strobe.wbOffer   = active && anyDirty;
    // move on once no dirty match is left after this cycle
    advance          = active && (!anyDirty || (wbReady && oneDirty));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      setIdx <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqPages == '0) begin
              doneQ <= 1'b1;
            end else begin
              state  <= ST_WALK;
              setIdx <= '0;
            end
          end
        end
        ST_WALK: begin
          if (advance) begin
            if (lastSet) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              setIdx <= setIdx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scrub_tag_store.sv
`timescale 1ns/1ps
module scrub_tag_store #(
  parameter int SET_BITS = 4,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 54,
  localparam int SETS    = 1 << SET_BITS,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lkValid,
  input  logic                lkWrite,
  input  logic [SET_BITS-1:0] lkSet,
  input  logic [TAG_W-1:0]    lkTag,
  input  logic                fillValid,
  input  logic                fillDirty,
  input  logic [SET_BITS-1:0] fillSet,
  input  logic [TAG_W-1:0]    fillTag,
  input  logic [SET_BITS-1:0] walkSet,
  input  logic [WAYS-1:0]     walkClear,
  output logic                lkHit,
  output logic [WAY_W-1:0]    lkWay,
  output logic [WAY_W-1:0]    lkVictim,
  output logic [WAYS-1:0]     walkValid,
  output logic [WAYS-1:0]     walkDirty,
  output logic [TAG_W-1:0]    walkTag [WAYS]
);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [WAYS-1:0]  dirtyMem [SETS];
  logic [WAY_W-1:0] rrPtr    [SETS];

  logic [WAY_W-1:0] fillVictim;
  logic             fillFull;

  // lowest invalid way wins; a full set falls back to its rotating pointer
  function automatic logic [WAY_W-1:0] pickVictim(input logic [WAYS-1:0] v,
                                                  input logic [WAY_W-1:0] rr);
    logic [WAY_W-1:0] r;
    r = rr;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    lkHit = 1'b0;
    lkWay = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (validMem[lkSet][i] && (tagMem[lkSet][i] == lkTag)) begin
        lkHit = 1'b1;
        lkWay = WAY_W'(i);
      end
    end
  end

  assign lkVictim   = pickVictim(validMem[lkSet], rrPtr[lkSet]);
  assign fillVictim = pickVictim(validMem[fillSet], rrPtr[fillSet]);
  assign fillFull   = &validMem[fillSet];
  assign walkValid  = validMem[walkSet];
  assign walkDirty  = dirtyMem[walkSet];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_walkTag
      assign walkTag[w] = tagMem[walkSet][w];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        rrPtr[s]    <= '0;
      end
    end else begin
      if (|walkClear) begin
        validMem[walkSet] <= validMem[walkSet] & ~walkClear;
        dirtyMem[walkSet] <= dirtyMem[walkSet] & ~walkClear;
      end
      if (lkValid && lkWrite && lkHit) begin
        dirtyMem[lkSet][lkWay] <= 1'b1;
      end
      if (fillValid) begin
        validMem[fillSet][fillVictim] <= 1'b1;
        dirtyMem[fillSet][fillVictim] <= fillDirty;
        if (fillFull) rrPtr[fillSet] <= rrPtr[fillSet] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fillValid) tagMem[fillSet][fillVictim] <= fillTag;
  end

endmodule

// File: rtl/scrub_datapath.sv
`timescale 1ns/1ps
module scrub_datapath
  import scrub_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_SHIFT = 6,
  parameter int SET_BITS   = 4,
  parameter int WAYS       = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int CNT_W      = 16,
  localparam int TAG_W     = ADDR_W - SET_BITS - LINE_SHIFT,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int RW        = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  scrubStrobe_t        strobe,
  input  logic [SET_BITS-1:0] walkSet,
  input  logic [ADDR_W-1:0]   reqBase,
  input  logic [CNT_W-1:0]    reqPages,
  input  logic                lkValid,
  input  logic [ADDR_W-1:0]   lkAddr,
  input  logic                lkWrite,
  input  logic                fillValid,
  input  logic [ADDR_W-1:0]   fillAddr,
  input  logic                fillDirty,
  input  logic                wbReady,
  output logic                lkHit,
  output logic [WAY_W-1:0]    lkWay,
  output logic [WAY_W-1:0]    lkVictim,
  output logic                wbValid,
  output logic [ADDR_W-1:0]   wbAddr,
  output logic                conflict,
  output logic                anyDirty,
  output logic                oneDirty
);

  logic [RW-1:0]       rangeLo, rangeHi, pageLo, pageSpan;
  logic [SET_BITS-1:0] lkSet, fillSet;
  logic [TAG_W-1:0]    lkTag, fillTag;
  logic [WAYS-1:0]     walkValid, walkDirty, walkClear;
  logic [TAG_W-1:0]    walkTag [WAYS];
  logic [WAYS-1:0]     inRange, dirtyMatch, cleanMatch, dirtyPick;
  logic [WAY_W-1:0]    pickIdx;
  logic                commit;
  logic                unusedAddrBits;

  assign unusedAddrBits = ^{reqBase[PAGE_SHIFT-1:0], lkAddr[LINE_SHIFT-1:0],
                            fillAddr[LINE_SHIFT-1:0]};

  assign lkSet   = lkAddr[LINE_SHIFT +: SET_BITS];
  assign lkTag   = lkAddr[ADDR_W-1 -: TAG_W];
  assign fillSet = fillAddr[LINE_SHIFT +: SET_BITS];
  assign fillTag = fillAddr[ADDR_W-1 -: TAG_W];

  // range bounds carry one extra bit so the upper bound cannot wrap
  assign pageLo   = {1'b0, reqBase[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign pageSpan = RW'(reqPages) << PAGE_SHIFT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeLo <= '0;
      rangeHi <= '0;
    end else if (strobe.loadRange) begin
      rangeLo <= pageLo;
      rangeHi <= pageLo + pageSpan;
    end
  end

  scrub_tag_store #(
    .SET_BITS(SET_BITS),
    .WAYS    (WAYS),
    .TAG_W   (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rstN     (rstN),
    .lkValid  (lkValid),
    .lkWrite  (lkWrite),
    .lkSet    (lkSet),
    .lkTag    (lkTag),
    .fillValid(fillValid),
    .fillDirty(fillDirty),
    .fillSet  (fillSet),
    .fillTag  (fillTag),
    .walkSet  (walkSet),
    .walkClear(walkClear),
    .lkHit    (lkHit),
    .lkWay    (lkWay),
    .lkVictim (lkVictim),
    .walkValid(walkValid),
    .walkDirty(walkDirty),
    .walkTag  (walkTag)
  );

  // one comparator pair per way, all ways of the walked set at once
  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_match
      logic [RW-1:0] lineAddr;
      assign lineAddr   = {1'b0, walkTag[w], walkSet, {LINE_SHIFT{1'b0}}};
      assign inRange[w] = walkValid[w] && (lineAddr >= rangeLo) && (lineAddr < rangeHi);
    end
  endgenerate

  assign dirtyMatch = inRange & walkDirty;
  assign cleanMatch = inRange & ~walkDirty;
  assign dirtyPick  = dirtyMatch & (~dirtyMatch + WAYS'(1));
  assign anyDirty   = |dirtyMatch;
  assign oneDirty   = anyDirty && (dirtyMatch == dirtyPick);

  always_comb begin
    pickIdx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (dirtyMatch[i]) pickIdx = WAY_W'(i);
    end
  end

  assign conflict = (lkValid && (lkSet == walkSet)) || (fillValid && (fillSet == walkSet));
  assign wbValid  = strobe.wbOffer;
  assign wbAddr   = {walkTag[pickIdx], walkSet, {LINE_SHIFT{1'b0}}};
  assign commit   = strobe.wbOffer && wbReady;

  always_comb begin
    walkClear = '0;
    if (strobe.scrubEn) begin
      walkClear = cleanMatch | (commit ? dirtyPick : '0);
    end
  end

endmodule

// File: rtl/range_scrubber.sv
`timescale 1ns/1ps
module range_scrubber
  import scrub_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_SHIFT = 6,
  parameter int SET_BITS   = 4,
  parameter int WAYS       = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int CNT_W      = 16,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [CNT_W-1:0]  reqPages,
  output logic              donePulse,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  output logic              lkHit,
  output logic [WAY_W-1:0]  lkWay,
  output logic [WAY_W-1:0]  lkVictim,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              fillDirty,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbReady
);

  scrubStrobe_t        strobe;
  logic [SET_BITS-1:0] walkSet;
  logic                conflict, anyDirty, oneDirty;

  scrub_ctrl #(
    .SET_BITS(SET_BITS),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqPages (reqPages),
    .conflict (conflict),
    .anyDirty (anyDirty),
    .oneDirty (oneDirty),
    .wbReady  (wbReady),
    .reqReady (reqReady),
    .donePulse(donePulse),
    .strobe   (strobe),
    .walkSet  (walkSet)
  );

  scrub_datapath #(
    .ADDR_W    (ADDR_W),
    .LINE_SHIFT(LINE_SHIFT),
    .SET_BITS  (SET_BITS),
    .WAYS      (WAYS),
    .PAGE_SHIFT(PAGE_SHIFT),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .walkSet  (walkSet),
    .reqBase  (reqBase),
    .reqPages (reqPages),
    .lkValid  (lkValid),
    .lkAddr   (lkAddr),
    .lkWrite  (lkWrite),
    .fillValid(fillValid),
    .fillAddr (fillAddr),
    .fillDirty(fillDirty),
    .wbReady  (wbReady),
    .lkHit    (lkHit),
    .lkWay    (lkWay),
    .lkVictim (lkVictim),
    .wbValid  (wbValid),
    .wbAddr   (wbAddr),
    .conflict (conflict),
    .anyDirty (anyDirty),
    .oneDirty (oneDirty)
  );

endmodule

// File: rtl/range_scrubber_chk.sv
`timescale 1ns/1ps
module range_scrubber_chk #(
  parameter int ADDR_W     = 64,
  parameter int LINE_SHIFT = 6,
  parameter int SET_BITS   = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int CNT_W      = 16,
  localparam int RW        = ADDR_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqBase,
  input logic [CNT_W-1:0]  reqPages,
  input logic              donePulse,
  input logic              lkValid,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              fillValid,
  input logic [ADDR_W-1:0] fillAddr,
  input logic              wbValid,
  input logic [ADDR_W-1:0] wbAddr
);

  logic [RW-1:0] chkLo, chkHi;
  logic          unusedChk;

  assign unusedChk = ^{reqBase[PAGE_SHIFT-1:0],
                       lkAddr[ADDR_W-1:LINE_SHIFT+SET_BITS], lkAddr[LINE_SHIFT-1:0],
                       fillAddr[ADDR_W-1:LINE_SHIFT+SET_BITS], fillAddr[LINE_SHIFT-1:0]};

  // independent copy of the accepted range, taken at the request port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkLo <= '0;
      chkHi <= '0;
    end else if (reqValid && reqReady) begin
      chkLo <= {1'b0, reqBase[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      chkHi <= {1'b0, reqBase[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}}
               + (RW'(reqPages) << PAGE_SHIFT);
    end
  end

  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqPages != '0)) |=> !reqReady);

  // R8
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqPages == '0)) |=> donePulse);

  // R6
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> reqReady);

  // R6
  wb_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !reqReady);

  // R2
  wb_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (({1'b0, wbAddr} >= chkLo) && ({1'b0, wbAddr} < chkHi)));

  // R4
  wb_line_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbAddr[LINE_SHIFT-1:0] == '0));

  // R7
  wb_yields_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !(lkValid && (lkAddr[LINE_SHIFT +: SET_BITS] == wbAddr[LINE_SHIFT +: SET_BITS])));

  // R7
  wb_yields_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !(fillValid && (fillAddr[LINE_SHIFT +: SET_BITS] == wbAddr[LINE_SHIFT +: SET_BITS])));

endmodule

bind range_scrubber range_scrubber_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_SHIFT(LINE_SHIFT),
  .SET_BITS  (SET_BITS),
  .PAGE_SHIFT(PAGE_SHIFT),
  .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/range_scrubber_tb.sv
`timescale 1ns/1ps
module range_scrubber_tb;

  localparam int SETS = 16;
  localparam int WAYS = 4;
  localparam logic [63:0] BASE = 64'h0000_0000_0004_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqBase = '0;
  logic [15:0] reqPages = '0;
  logic        donePulse;
  logic        lkValid = 1'b0;
  logic [63:0] lkAddr = '0;
  logic        lkWrite = 1'b0;
  logic        lkHit;
  logic [1:0]  lkWay;
  logic [1:0]  lkVictim;
  logic        fillValid = 1'b0;
  logic [63:0] fillAddr = '0;
  logic        fillDirty = 1'b0;
  logic        wbValid;
  logic [63:0] wbAddr;
  logic        wbReady = 1'b0;

  int nCmp = 0;
  int nBad = 0;

  logic [63:0] mAddr  [SETS][WAYS];
  bit          mValid [SETS][WAYS];
  bit          mDirty [SETS][WAYS];

  always #4 clk = ~clk;

  range_scrubber u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqBase(reqBase), .reqPages(reqPages),
    .donePulse(donePulse),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite),
    .lkHit(lkHit), .lkWay(lkWay), .lkVictim(lkVictim),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillDirty(fillDirty),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbReady(wbReady)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookupAll(input string req);
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        @(negedge clk);
        lkValid = 1'b1; lkWrite = 1'b0; lkAddr = mAddr[s][w];
        #1;
        chk(lkHit == mValid[s][w], req, 64'(lkHit), 64'(mValid[s][w]));
        if (mValid[s][w] && lkHit) chk(lkWay == 2'(w), req, 64'(lkWay), 64'(w));
      end
    end
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic refill(input int r);
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!mValid[s][w]) begin
          int p;
          bit clash;
          logic [63:0] cand;
          p = (w + s + r) % 8;
          do begin
            cand  = BASE + 64'(p) * 4096 + 64'(s) * 64;
            clash = 1'b0;
            for (int v = 0; v < WAYS; v++)
              if (mValid[s][v] && mAddr[s][v] == cand) clash = 1'b1;
            if (clash) p = (p + 1) % 8;
          end while (clash);
          @(negedge clk);
          lkAddr = cand;
          #1;
          // R5 R10: the lowest invalid way is the fill target
          chk(lkVictim == 2'(w), "R5 R10 victim way", 64'(lkVictim), 64'(w));
          fillValid = 1'b1; fillAddr = cand; fillDirty = ((s + w + r) % 3 == 0);
          mAddr[s][w] = cand; mValid[s][w] = 1'b1; mDirty[s][w] = fillDirty;
          @(negedge clk);
          fillValid = 1'b0;
        end
      end
    end
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (mValid[s][w] && !mDirty[s][w] && ((s + w + r) % 4 == 1)) begin
          @(negedge clk);
          lkValid = 1'b1; lkWrite = 1'b1; lkAddr = mAddr[s][w];
          #1;
          // R10: store hit marks the line dirty
          chk(lkHit == 1'b1, "R10 store hit", 64'(lkHit), 64'd1);
          mDirty[s][w] = 1'b1;
          @(negedge clk);
          lkValid = 1'b0; lkWrite = 1'b0;
        end
      end
    end
  endtask

  task automatic runScrub(input int page, input int cnt, input logic [11:0] low,
                          input bit inject, output int cycles);
    logic [63:0] lo, hi;
    int expDirty, wbCnt;
    bit probed, found;
    lo = BASE + 64'(page) * 4096;
    hi = lo + 64'(cnt) * 4096;
    expDirty = 0; wbCnt = 0; probed = 1'b0; cycles = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (mValid[s][w] && mDirty[s][w] && mAddr[s][w] >= lo && mAddr[s][w] < hi) expDirty++;
    @(negedge clk);
    chk(reqReady == 1'b1, "R6 ready before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqBase = lo | 64'(low); reqPages = 16'(cnt);
    while (1) begin
      @(negedge clk);
      cycles++;
      reqValid = 1'b0; lkValid = 1'b0;
      wbReady = (cycles % 3 != 1);
      if (cycles == 1 && inject) begin
        lkValid = 1'b1; lkAddr = BASE;
      end
      #1;
      if (donePulse) break;
      if (cycles == 1) chk(reqReady == 1'b0, "R6 busy not ready", 64'(reqReady), 64'd0);
      if (wbValid && !probed && !inject) begin
        probed = 1'b1; wbReady = 1'b0; lkValid = 1'b1; lkAddr = wbAddr;
        #1;
        // R4: still valid while the writeback is pending; R7: walk yields
        chk(lkHit == 1'b1, "R4 pending dirty line valid", 64'(lkHit), 64'd1);
        chk(wbValid == 1'b0, "R7 walk yields to lookup", 64'(wbValid), 64'd0);
        continue;
      end
      if (wbValid && wbReady) begin
        found = 1'b0;
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (mValid[s][w] && mDirty[s][w] && mAddr[s][w] == wbAddr
                && wbAddr >= lo && wbAddr < hi) begin
              found = 1'b1; mDirty[s][w] = 1'b0;
            end
        // R3 R4: only dirty in-range lines, each exactly once
        chk(found, "R3 R4 writeback address", wbAddr, lo);
        wbCnt++;
      end
    end
    wbReady = 1'b0;
    chk(wbCnt == expDirty, "R4 writeback count", 64'(wbCnt), 64'(expDirty));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (mValid[s][w] && mAddr[s][w] >= lo && mAddr[s][w] < hi) begin
          mValid[s][w] = 1'b0; mDirty[s][w] = 1'b0;
        end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int cyc, pg, cn;
    logic [11:0] lw;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mAddr[s][w] = BASE + 64'(s) * 64; mValid[s][w] = 1'b0; mDirty[s][w] = 1'b0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(reqReady == 1'b1, "R1 reset ready", 64'(reqReady), 64'd1);
    chk(donePulse == 1'b0, "R1 reset done", 64'(donePulse), 64'd0);
    chk(wbValid == 1'b0, "R1 reset writeback", 64'(wbValid), 64'd0);
    lookupAll("R1 empty after reset");

    for (int r = 0; r < 7; r++) begin
      case (r)
        0: begin pg = 1; cn = 1; lw = 12'h000; end
        1: begin pg = 2; cn = 2; lw = 12'h7FF; end  // R9 unaligned base
        2: begin pg = 0; cn = 0; lw = 12'h000; end  // R8 zero length
        3: begin pg = 3; cn = 3; lw = 12'h123; end  // R9 unaligned base
        4: begin pg = 0; cn = 8; lw = 12'h000; end
        5: begin pg = 6; cn = 1; lw = 12'hFFF; end
        default: begin pg = 9; cn = 2; lw = 12'h000; end
      endcase
      refill(r);
      runScrub(pg, cn, lw, 1'b0, cyc);
      if (cn == 0) chk(cyc == 1, "R8 zero length latency", 64'(cyc), 64'd1);
      lookupAll("R2 R3 R5 R9 line state after scrub");
    end

    refill(7);
    runScrub(9, 2, 12'h000, 1'b0, cyc);
    chk(cyc == SETS + 1, "R6 walk latency", 64'(cyc), 64'(SETS + 1));
    runScrub(9, 2, 12'h000, 1'b1, cyc);
    chk(cyc == SETS + 2, "R7 conflict stall latency", 64'(cyc), 64'(SETS + 2));
    lookupAll("R2 R7 untouched lines kept");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule